// File: doc/BRIEF.md
# Cache Line Fill Qualifier

This block sits between the core's bus unit and its on-chip cache. For each read cycle it decides whether the transfer turns into a multi-beat cache line fill and, at the end of a fill, whether the line may be written into the cache. It also turns an external snoop request into a one-clock invalidate pulse for the tag logic.

The core opens a read cycle with a one-clock start pulse and a cacheable flag. The system answers each transfer with a ready or a burst-ready strobe. The active-low cache-enable input is registered on every clock, so the value from the clock before each ready is available when that ready arrives. Cacheability is judged twice. The first judgement, on the first transfer, turns the cycle into a fill. The second, on the last transfer, decides whether the fill is committed or discarded. A discarded fill still hands every captured beat to the core.

While an external master holds the address bus, the block tells the bus unit to release only its address drivers, starting one clock after the request. A falling edge on the active-low external-address strobe captures the snoop address and raises an invalidate pulse.

Top module: `linefill_qual`

## Requirements
- R1: After reset, line_fill, cap_stb, commit, addr_float and inval are all 0.
- R2: When a cycle is cacheable and cache-enable was sampled active (cen_n = 0) on the clock before the first transfer's ready, line_fill rises one clock after that ready and stays high until one clock after the last transfer's ready.
- R3: If the cycle is not cacheable, or cache-enable was inactive on the clock before the first ready, the cycle ends after that one transfer, line_fill stays 0 and no commit is produced.
- R4: cap_stb pulses one clock after every ready or burst-ready that completes a transfer of an open cycle. A ready with no open cycle gives no pulse.
- R5: A fill ends after BEATS transfers (default 4), counted over rdy or brdy. commit pulses for exactly one clock, one clock after the last ready, when cen_n was 0 on the clock before that ready.
- R6: If cen_n was 1 on the clock before the last ready, the fill is discarded: commit stays 0, but cap_stb still pulses for the last beat.
- R7: A cycle start pulse while a cycle is open is ignored.
- R8: addr_float equals the value ahold had on the previous clock.
- R9: A 1-to-0 change of eads_n, sampled on a clock, gives inval = 1 for exactly one clock on the next clock, with inval_addr equal to snoop_addr from that sampling clock. Holding eads_n low gives no further pulses.
- R10: cen_n is active low: 0 enables caching and 1 disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse that opens a read cycle |
| cyc_cacheable | input | 1 | The core allows this cycle to be cached |
| cen_n | input | 1 | Active-low cache enable from the system |
| rdy | input | 1 | Transfer-complete strobe |
| brdy | input | 1 | Burst transfer-complete strobe |
| ahold | input | 1 | External master requests the address bus |
| eads_n | input | 1 | Active-low strobe marking a valid snoop address |
| snoop_addr | input | ADDR_W | Snoop address driven by the external master |
| line_fill | output | 1 | The current cycle is a line fill |
| cap_stb | output | 1 | A data beat is to be captured |
| commit | output | 1 | One-clock pulse: write the filled line into the cache |
| addr_float | output | 1 | Release the address bus drivers |
| inval | output | 1 | One-clock invalidate request |
| inval_addr | output | ADDR_W | Address to invalidate |

## Verification
A wrong beat count shows up as commit arriving on the wrong ready, or as line_fill staying high past the fourth capture. A wrong sampled enable flips line_fill or commit within one clock of the ready concerned. A stale cycle-open state shows as a capture strobe on a stray ready. The reference model follows every output on every clock, so any such error is reported on the clock where it first reaches a port.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_FILL  = 2'd2
  } fill_st_t;
endpackage

// File: rtl/lf_cen_sampler.sv
module lf_cen_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cen_n,
  output logic cen_ok
);
  // Enable as it stood on the previous clock, active high.
  always_ff @(posedge clk) begin
    if (rst) cen_ok <= 1'b0;
    else     cen_ok <= ~cen_n;
  end
endmodule

// File: rtl/lf_fill_fsm.sv
module lf_fill_fsm
  import lf_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic cyc_cacheable,
  input  logic cen_ok,
  input  logic rdy,
  input  logic brdy,
  output logic line_fill,
  output logic cap_stb,
  output logic commit
);
  localparam int CNT_W = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  fill_st_t         st;
  logic [CNT_W-1:0] beat;
  logic             cach_q;
  logic             rdy_any;

  assign rdy_any = rdy | brdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      beat      <= '0;
      cach_q    <= 1'b0;
      line_fill <= 1'b0;
      cap_stb   <= 1'b0;
      commit    <= 1'b0;
    end else begin
      cap_stb <= 1'b0;
      commit  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cyc_start) begin
            st     <= ST_FIRST;
            cach_q <= cyc_cacheable;
          end
        end
        ST_FIRST: begin
          if (rdy_any) begin
            cap_stb <= 1'b1;
            if (cach_q && cen_ok) begin
              st        <= ST_FILL;
              line_fill <= 1'b1;
              beat      <= CNT_W'(1);
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_FILL: begin
          if (rdy_any) begin
            cap_stb <= 1'b1;
            if (beat == LAST) begin
              commit    <= cen_ok;
              line_fill <= 1'b0;
              st        <= ST_IDLE;
            end else begin
              beat <= beat + CNT_W'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: a capture always follows a ready
  a_r4_cap_after_ready: assert property (@(posedge clk) disable iff (rst)
    cap_stb |-> $past(rdy_any));
  // R2: fill mode only starts when the enable was seen active
  a_r2_fill_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(line_fill) |-> $past(cen_ok));
  // R5: commit only closes a fill in progress
  a_r5_commit_ends_fill: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(line_fill) && !line_fill));
  // R5: commit is a single-clock pulse
  a_r5_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
endmodule

// File: rtl/lf_snoop.sv
module lf_snoop #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ahold,
  input  logic              eads_n,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              addr_float,
  output logic              inval,
  output logic [ADDR_W-1:0] inval_addr
);
  logic eads_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_float <= 1'b0;
      inval      <= 1'b0;
      eads_q     <= 1'b1;
      inval_addr <= '0;
    end else begin
      addr_float <= ahold;
      eads_q     <= eads_n;
      inval      <= eads_q & ~eads_n;
      if (eads_q && !eads_n) inval_addr <= snoop_addr;
    end
  end

  // R8: address release trails the hold request by one clock
  a_r8_float_follows: assert property (@(posedge clk) disable iff (rst)
    ahold |=> addr_float);
  // R9: invalidate comes from a sampled strobe
  a_r9_inval_from_strobe: assert property (@(posedge clk) disable iff (rst)
    inval |-> $past(!eads_n));
  // R9: invalidate lasts one clock
  a_r9_inval_single: assert property (@(posedge clk) disable iff (rst)
    inval |=> !inval);
endmodule

// File: rtl/linefill_qual.sv
module linefill_qual #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              cyc_cacheable,
  input  logic              cen_n,
  input  logic              rdy,
  input  logic              brdy,
  input  logic              ahold,
  input  logic              eads_n,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              line_fill,
  output logic              cap_stb,
  output logic              commit,
  output logic              addr_float,
  output logic              inval,
  output logic [ADDR_W-1:0] inval_addr
);
  logic cen_ok;

  lf_cen_sampler u_cen (
    .clk    (clk),
    .rst    (rst),
    .cen_n  (cen_n),
    .cen_ok (cen_ok)
  );

  lf_fill_fsm #(.BEATS(BEATS)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .cyc_start     (cyc_start),
    .cyc_cacheable (cyc_cacheable),
    .cen_ok        (cen_ok),
    .rdy           (rdy),
    .brdy          (brdy),
    .line_fill     (line_fill),
    .cap_stb       (cap_stb),
    .commit        (commit)
  );

  lf_snoop #(.ADDR_W(ADDR_W)) u_snoop (
    .clk        (clk),
    .rst        (rst),
    .ahold      (ahold),
    .eads_n     (eads_n),
    .snoop_addr (snoop_addr),
    .addr_float (addr_float),
    .inval      (inval),
    .inval_addr (inval_addr)
  );

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !(line_fill || cap_stb || commit || inval || addr_float));
endmodule

// File: tb/linefill_qual_tb.sv
module linefill_qual_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, cyc_cacheable = 1'b0, cen_n = 1'b1;
  logic rdy = 1'b0, brdy = 1'b0, ahold = 1'b0, eads_n = 1'b1;
  logic [AW-1:0] snoop_addr = '0;
  logic line_fill, cap_stb, commit, addr_float, inval;
  logic [AW-1:0] inval_addr;

  int checks = 0;
  int fails  = 0;
  bit rnd_snoop = 1'b0;

  always #5 clk = ~clk;

  linefill_qual #(.ADDR_W(AW), .BEATS(4)) u_dut (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_cacheable(cyc_cacheable),
    .cen_n(cen_n), .rdy(rdy), .brdy(brdy), .ahold(ahold), .eads_n(eads_n),
    .snoop_addr(snoop_addr), .line_fill(line_fill), .cap_stb(cap_stb),
    .commit(commit), .addr_float(addr_float), .inval(inval), .inval_addr(inval_addr)
  );

  // Behavioural reference model, advanced on every rising edge
  bit m_open = 0, m_cach = 0, m_en = 0, m_eprev = 1;
  int m_beat = 0;
  bit e_fill = 0, e_cap = 0, e_commit = 0, e_float = 0, e_inval = 0;
  logic [AW-1:0] e_iaddr = '0;

  always @(posedge clk) begin
    e_cap = 0; e_commit = 0; e_inval = 0;
    if (rst) begin
      m_open = 0; m_cach = 0; m_en = 0; m_eprev = 1; m_beat = 0;
      e_fill = 0; e_float = 0; e_iaddr = '0;
    end else begin
      if (!m_open) begin
        if (cyc_start) begin m_open = 1; m_cach = cyc_cacheable; m_beat = 0; end
      end else if (rdy || brdy) begin
        e_cap = 1;
        if (m_beat == 0) begin
          if (m_cach && m_en) begin e_fill = 1; m_beat = 1; end
          else m_open = 0;
        end else if (m_beat == 3) begin
          e_commit = m_en; e_fill = 0; m_open = 0;
        end else m_beat = m_beat + 1;
      end
      e_float = ahold;
      if (!eads_n && m_eprev) begin e_inval = 1; e_iaddr = snoop_addr; end
      m_eprev = eads_n;
      m_en = !cen_n;
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 model line_fill", line_fill, e_fill);
      chk("R4 model cap_stb", cap_stb, e_cap);
      chk("R5 model commit", commit, e_commit);
      chk("R8 model addr_float", addr_float, e_float);
      chk("R9 model inval", inval, e_inval);
      if (e_inval) chk("R9 model inval_addr", inval_addr, e_iaddr);
    end
  end

  always @(negedge clk) begin
    if (rnd_snoop) begin
      ahold      <= 1'($urandom_range(0, 1));
      eads_n     <= 1'($urandom_range(0, 3) != 0);
      snoop_addr <= $urandom;
    end
  end

  task automatic run_cycle(input bit cach, input bit en1, input bit en2,
                           input bit burst, input bit gaps);
    @(negedge clk); cyc_start = 1; cyc_cacheable = cach; cen_n = !en1;
    @(negedge clk); cyc_start = 0; cen_n = 1;
    if (burst) brdy = 1; else rdy = 1;
    @(negedge clk); rdy = 0; brdy = 0;
    chk("R4 first capture", cap_stb, 1);
    chk("R2 R3 R10 fill decision", line_fill, cach && en1);
    if (!(cach && en1)) begin
      chk("R3 no commit", commit, 0);
      return;
    end
    for (int b = 1; b < 3; b++) begin
      if (gaps) @(negedge clk);
      if (b == 1) begin cyc_start = 1; cyc_cacheable = 0; end
      if (burst) brdy = 1; else rdy = 1;
      @(negedge clk); rdy = 0; brdy = 0; cyc_start = 0;
      chk("R4 mid capture", cap_stb, 1);
      chk("R7 fill kept", line_fill, 1);
    end
    cen_n = !en2;
    @(negedge clk); cen_n = 1; brdy = 1;
    @(negedge clk); brdy = 0;
    chk("R5 fill ends", line_fill, 0);
    if (en2) chk("R5 commit", commit, 1);
    else     chk("R6 discard", commit, 0);
    chk("R6 last capture", cap_stb, 1);
    @(negedge clk);
    chk("R5 commit one clock", commit, 0);
    rdy = 1;
    @(negedge clk); rdy = 0;
    chk("R7 R4 idle ready ignored", cap_stb, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk("R1 line_fill", line_fill, 0);
    chk("R1 cap_stb", cap_stb, 0);
    chk("R1 commit", commit, 0);
    chk("R1 addr_float", addr_float, 0);
    chk("R1 inval", inval, 0);
    rst = 0;

    run_cycle(1, 1, 1, 0, 0);
    run_cycle(1, 1, 0, 1, 1);
    run_cycle(0, 1, 1, 0, 0);
    run_cycle(1, 0, 1, 1, 0);
    run_cycle(1, 1, 1, 1, 1);

    @(negedge clk); ahold = 1;
    @(negedge clk); chk("R8 release", addr_float, 1);
    ahold = 0;
    @(negedge clk); chk("R8 drive again", addr_float, 0);

    snoop_addr = 32'h1234_5670; eads_n = 0;
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      snoop_addr = 32'hdead_0000;
      if (inval) begin
        pulses++;
        chk("R9 address", inval_addr, 32'h1234_5670);
      end
    end
    eads_n = 1;
    chk("R9 single pulse", pulses, 1);

    rnd_snoop = 1;
    for (int k = 0; k < 40; k++) begin
      run_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
    end
    rnd_snoop = 0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule